// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes serial PCM audio arriving on a data line, a bit clock and a frame (word-select) clock, and turns it into parallel samples. A one-cycle strobe marks each sample and a flag tells whether it belongs to the left or the right channel. All logic runs on one system clock. The serial clocks are treated as slow signals and are either sampled from the pins or generated internally.

The framing format is chosen at run time: I2S, left-justified or right-justified. A second run-time input picks the clocking role. As a clock slave the block receives the bit clock and frame clock. As a clock master it divides a supplied high-rate reference clock to produce both, and drives them out with an output enable. Mastering needs both the master select and a reference-enable input. Without them the clock outputs stay low and undriven. Sample width, slot length per channel and the reference divide ratio are parameters (sample width at least 2 and strictly below the slot length).

Top module: `srx_port`

## Requirements
- R1: While reset is asserted, smp_valid, smp_data, clk_oe, sclk_out and lrclk_out are all zero.
- R2: With fmt = 0 (I2S), a low frame clock marks the left channel and a high one the right. The sample MSB is the second bit of the channel slot, counted from the first rising bit-clock edge after a frame-clock change, and the next SAMPLE_W bits are taken MSB first.
- R3: With fmt = 1 (left-justified, and also for the unused code fmt = 3), a high frame clock marks the left channel. The MSB is the first bit of the slot, and the first SAMPLE_W bits are taken MSB first.
- R4: With fmt = 2 (right-justified), a high frame clock marks the left channel. The sample is the last SAMPLE_W bits of the SLOT_W-bit slot, with the LSB in the final bit position.
- R5: Each captured sample raises smp_valid for exactly one cycle, with smp_right = 1 for the right channel. Successive samples alternate between the two channels. Bits of a slot outside the sample window have no effect on smp_data.
- R6: In slave mode, sclk_in, lrclk_in and sdata pass through a two-flop synchroniser, and data is captured on the rising edges of the synchronised bit clock.
- R7: In master mode with ref_en high, clk_oe is high and sclk_out has a period of 2*REF_DIV rising edges of ref_clk. lrclk_out toggles every SLOT_W bit-clock periods and changes only on a falling edge of sclk_out. Serial data is captured on the rising edges of the generated bit clock.
- R8: One cycle after master or ref_en is low, clk_oe, sclk_out and lrclk_out are all zero.
- R9: After reset no sample is produced until the frame clock has changed level at least once, as seen at a rising bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| fmt | input | 2 | Framing select: 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| master | input | 1 | 1 selects clock master, 0 clock slave |
| ref_en | input | 1 | High when the reference clock is usable for mastering |
| ref_clk | input | 1 | High-rate reference clock used to derive the serial clocks |
| sclk_in | input | 1 | Bit clock from an external master |
| lrclk_in | input | 1 | Frame clock from an external master |
| sdata | input | 1 | Serial audio data |
| sclk_out | output | 1 | Generated bit clock |
| lrclk_out | output | 1 | Generated frame clock |
| clk_oe | output | 1 | Output enable for sclk_out and lrclk_out |
| smp_data | output | SAMPLE_W | Last captured sample |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_right | output | 1 | Channel of the sample on smp_data, 1 = right |

## Verification
A wrong slot bit counter or a wrong window bound shows within one frame as a sample shifted by one or more bits, or as padding bits leaking into smp_data. A channel-flag or arming fault shows on the first strobe after reset, as a wrong smp_right or as a strobe that arrives too early. A fault in the master divider shows within one bit-clock period as a wrong sclk_out period, or within one slot as a frame-clock edge that lands off the falling bit-clock edge.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_RSV = 2'd3
    } srx_fmt_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
    parameter int SLOT_W  = 24,
    parameter int REF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_tick,
    output logic sclk,
    output logic lrclk,
    output logic rise
);
    localparam int DW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam int PW = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(REF_DIV - 1);
    localparam logic [PW-1:0] POS_LAST = PW'(SLOT_W - 1);

    typedef struct packed {
        logic [DW-1:0] div;
        logic [PW-1:0] pos;
        logic          sclk;
        logic          lr;
        logic          rise;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        if (!run) begin
            st_d = '0;
        end else if (ref_tick) begin
            if (st_q.div == DIV_LAST) begin
                st_d.div  = '0;
                st_d.sclk = !st_q.sclk;
                if (!st_q.sclk) begin
                    st_d.rise = 1'b1;
                end else if (st_q.pos == POS_LAST) begin
                    st_d.pos = '0;
                    st_d.lr  = !st_q.lr;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk  = st_q.sclk;
    assign lrclk = st_q.lr;
    assign rise  = st_q.rise;
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  srx_fmt_e            fmt,
    input  logic                bit_rise,
    input  logic                lr,
    input  logic                din,
    output logic [SAMPLE_W-1:0] data,
    output logic                valid,
    output logic                right
);
    localparam int IW = $clog2(SLOT_W + 1) + 1;
    localparam logic [IW-1:0] IDX_MAX = '1;

    typedef struct packed {
        logic                lr_prev;
        logic                armed;
        logic [IW-1:0]       idx;
        logic [SAMPLE_W-1:0] sh;
        logic [SAMPLE_W-1:0] data;
        logic                valid;
        logic                right;
    } frm_t;

    frm_t st_d, st_q;
    logic [IW-1:0] win_lo, win_hi, cur;
    logic          lr_edge, arm, in_win;

    always_comb begin
        case (fmt)
            FMT_I2S: begin
                win_lo = IW'(1);
                win_hi = IW'(SAMPLE_W);
            end
            FMT_RJ: begin
                win_lo = IW'(SLOT_W - SAMPLE_W);
                win_hi = IW'(SLOT_W - 1);
            end
            default: begin
                win_lo = '0;
                win_hi = IW'(SAMPLE_W - 1);
            end
        endcase

        st_d       = st_q;
        st_d.valid = 1'b0;
        lr_edge    = 1'b0;
        cur        = st_q.idx;
        arm        = st_q.armed;
        in_win     = 1'b0;

        if (bit_rise) begin
            lr_edge      = (lr != st_q.lr_prev);
            st_d.lr_prev = lr;
            if (lr_edge)                 cur = '0;
            else if (st_q.idx != IDX_MAX) cur = st_q.idx + 1'b1;
            st_d.idx   = cur;
            arm        = st_q.armed | lr_edge;
            st_d.armed = arm;
            in_win     = arm && (cur >= win_lo) && (cur <= win_hi);
            if (in_win) begin
                st_d.sh = {st_q.sh[SAMPLE_W-2:0], din};
                if (cur == win_hi) begin
                    st_d.valid = 1'b1;
                    st_d.data  = {st_q.sh[SAMPLE_W-2:0], din};
                    st_d.right = (fmt == FMT_I2S) ? lr : !lr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data  = st_q.data;
    assign valid = st_q.valid;
    assign right = st_q.right;
endmodule

// File: rtl/srx_port.sv
module srx_port
    import srx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 24,
    parameter int REF_DIV  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt,
    input  logic                master,
    input  logic                ref_en,
    input  logic                ref_clk,
    input  logic                sclk_in,
    input  logic                lrclk_in,
    input  logic                sdata,
    output logic                sclk_out,
    output logic                lrclk_out,
    output logic                clk_oe,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic                smp_valid,
    output logic                smp_right
);
    typedef struct packed {
        logic ref_prev;
        logic sclk_prev;
        logic oe;
    } top_t;

    top_t       st_d, st_q;
    logic [3:0] pins_s;
    logic       s_ref, s_sclk, s_lr, s_dat;
    logic       run, ref_tick, slave_rise;
    logic       gen_sclk, gen_lr, gen_rise;
    logic       bit_rise, lr_sel;

    srx_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ref_clk, sclk_in, lrclk_in, sdata}),
        .q     (pins_s)
    );

    assign {s_ref, s_sclk, s_lr, s_dat} = pins_s;

    always_comb begin
        run           = master & ref_en;
        ref_tick      = s_ref & !st_q.ref_prev;
        slave_rise    = !run & s_sclk & !st_q.sclk_prev;
        st_d.ref_prev  = s_ref;
        st_d.sclk_prev = s_sclk;
        st_d.oe        = run;
        bit_rise      = run ? gen_rise : slave_rise;
        lr_sel        = run ? gen_lr : s_lr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    srx_clkgen #(.SLOT_W(SLOT_W), .REF_DIV(REF_DIV)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ref_tick (ref_tick),
        .sclk     (gen_sclk),
        .lrclk    (gen_lr),
        .rise     (gen_rise)
    );

    srx_framer #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt      (srx_fmt_e'(fmt)),
        .bit_rise (bit_rise),
        .lr       (lr_sel),
        .din      (s_dat),
        .data     (smp_data),
        .valid    (smp_valid),
        .right    (smp_right)
    );

    assign sclk_out  = gen_sclk;
    assign lrclk_out = gen_lr;
    assign clk_oe    = st_q.oe;
endmodule

// File: rtl/srx_port_chk.sv
module srx_port_chk (
    input logic clk,
    input logic rst_n,
    input logic master,
    input logic ref_en,
    input logic clk_oe,
    input logic sclk_out,
    input logic lrclk_out,
    input logic smp_valid,
    input logic smp_right
);
    logic seen_q, last_right_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q       <= 1'b0;
            last_right_q <= 1'b0;
        end else if (smp_valid) begin
            seen_q       <= 1'b1;
            last_right_q <= smp_right;
        end
    end

    // R8
    undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(master && ref_en) |-> (!clk_oe && !sclk_out && !lrclk_out));

    // R7
    lr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_oe && $past(clk_oe) && (lrclk_out != $past(lrclk_out)))
            |-> ($past(sclk_out) && !sclk_out));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R5
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && seen_q) |-> (smp_right != last_right_q));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!smp_valid && !clk_oe));
endmodule

bind srx_port srx_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .master    (master),
    .ref_en    (ref_en),
    .clk_oe    (clk_oe),
    .sclk_out  (sclk_out),
    .lrclk_out (lrclk_out),
    .smp_valid (smp_valid),
    .smp_right (smp_right)
);

// File: tb/srx_port_bench.sv
module srx_port_bench;
    localparam int N  = 8;
    localparam int S  = 10;
    localparam int RD = 2;
    localparam int H  = 4;
    localparam logic [N-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   fmt = 2'd0;
    logic         master = 1'b0;
    logic         ref_en = 1'b0;
    logic         ref_clk = 1'b0;
    logic         sclk_in = 1'b0;
    logic         lrclk_in = 1'b0;
    logic         sdata = 1'b0;
    logic         sclk_out, lrclk_out, clk_oe;
    logic [N-1:0] smp_data;
    logic         smp_valid, smp_right;

    int n_chk = 0;
    int n_fail = 0;

    logic [N-1:0] exp_d [0:511];
    logic         exp_r [0:511];
    int           exp_n = 0;
    logic [N-1:0] rx_d [0:511];
    logic         rx_r [0:511];
    int           rx_n = 0;

    int cyc = 0;
    int last_rise = -1, last_lr = -1, n_int = 0, n_lrint = 0;
    logic mon_sclk = 1'b0, mon_lr = 1'b0;

    logic         tx_on = 1'b0;
    int           tx_fmt = 0, tx_idx = 0, tx_frame = 0;
    logic         tx_sclk = 1'b0, tx_lr = 1'b0;
    logic [N-1:0] tx_s = '1;

    always #4 clk = ~clk;

    initial forever begin
        repeat (2) @(negedge clk);
        ref_clk = ~ref_clk;
    end

    srx_port #(.SAMPLE_W(N), .SLOT_W(S), .REF_DIV(RD)) u_srx_port (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .master(master), .ref_en(ref_en),
        .ref_clk(ref_clk), .sclk_in(sclk_in), .lrclk_in(lrclk_in), .sdata(sdata),
        .sclk_out(sclk_out), .lrclk_out(lrclk_out), .clk_oe(clk_oe),
        .smp_data(smp_data), .smp_valid(smp_valid), .smp_right(smp_right)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] left_of(input int f, input int c);
        return N'(f * 4 + c);
    endfunction

    function automatic logic [N-1:0] sample_of(input int f, input logic r, input int c);
        return r ? (MASK - left_of(f, c)) : left_of(f, c);
    endfunction

    function automatic logic bit_of(input int f, input logic [N-1:0] s, input int i);
        if (f == 0) return (i >= 1 && i <= N) ? s[N-i] : 1'b1;
        if (f == 2) return (i >= S - N) ? s[S-1-i] : 1'b1;
        return (i < N) ? s[N-1-i] : 1'b1;
    endfunction

    function automatic string req_of(input int f);
        if (f == 0) return "R2";
        if (f == 2) return "R4";
        return "R3";
    endfunction

    // sample monitor plus master-clock timing checks (R7)
    always @(negedge clk) begin
        cyc++;
        if (rst_n && smp_valid && rx_n < 512) begin
            rx_d[rx_n] = smp_data;
            rx_r[rx_n] = smp_right;
            rx_n++;
        end
        if (rst_n && clk_oe) begin
            if (sclk_out && !mon_sclk) begin
                if (last_rise >= 0 && n_int < 6) begin
                    chk("R7", "sclk_out period", cyc - last_rise, 2 * RD * 4);
                    n_int++;
                end
                last_rise = cyc;
            end
            if (lrclk_out != mon_lr) begin
                if (last_lr >= 0 && n_lrint < 3) begin
                    chk("R7", "lrclk_out half period", cyc - last_lr, S * 2 * RD * 4);
                    n_lrint++;
                end
                last_lr = cyc;
            end
        end
        mon_sclk = sclk_out;
        mon_lr   = lrclk_out;
    end

    // transmitter model driven by the generated clocks (master mode)
    always @(negedge clk) begin
        if (tx_on && tx_sclk && !sclk_out) begin
            if (lrclk_out != tx_lr) begin
                logic rch;
                tx_lr  = lrclk_out;
                tx_idx = 0;
                rch = (tx_fmt == 0) ? lrclk_out : !lrclk_out;
                if (!rch) tx_frame++;
                tx_s = sample_of(tx_frame, rch, tx_fmt);
                if (exp_n < 512) begin
                    exp_d[exp_n] = tx_s;
                    exp_r[exp_n] = rch;
                    exp_n++;
                end
            end else begin
                tx_idx++;
            end
            sdata = bit_of(tx_fmt, tx_s, tx_idx);
        end
        tx_sclk = sclk_out;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tx_on = 1'b0;
        sclk_in = 1'b0; lrclk_in = 1'b0; sdata = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "smp_valid in reset", smp_valid, 0);
        chk("R1", "smp_data in reset", smp_data, 0);
        chk("R1", "clk_oe/sclk/lrclk in reset", {clk_oe, sclk_out, lrclk_out}, 0);
        rx_n = 0; exp_n = 0;
        last_rise = -1; last_lr = -1; n_int = 0; n_lrint = 0;
        tx_idx = 0; tx_frame = 0; tx_lr = 1'b0; tx_s = '1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic slave_bit(input logic lr, input logic d);
        @(negedge clk);
        sclk_in = 1'b0; lrclk_in = lr; sdata = d;
        repeat (H) @(negedge clk);
        sclk_in = 1'b1;
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic slave_phase(input int f, input logic rch, input logic [N-1:0] s, input bit log_it);
        logic lr;
        lr = (f == 0) ? rch : !rch;
        for (int i = 0; i < S; i++) slave_bit(lr, bit_of(f, s, i));
        if (log_it) begin
            exp_d[exp_n] = s;
            exp_r[exp_n] = rch;
            exp_n++;
        end
    endtask

    task automatic compare(input string req, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            chk(req, $sformatf("sample %0d data", i), rx_d[i], exp_d[i]);
            chk("R5", $sformatf("sample %0d channel", i), rx_r[i], exp_r[i]);
        end
    endtask

    initial begin
        // slave sweeps (R6) over every format code
        for (int c = 0; c < 4; c++) begin
            int frames;
            frames = (c == 3) ? 8 : 64;
            fmt = 2'(c); master = 1'b0; ref_en = 1'b1;
            do_reset();
            chk("R8", "slave mode clocks undriven", {clk_oe, sclk_out, lrclk_out}, 0);
            // R9: frame clock never moves, padding of ones
            for (int i = 0; i < 3 * S; i++) slave_bit(1'b0, 1'b1);
            chk("R9", "no sample before frame edge", rx_n, 0);
            slave_phase(c, 1'b1, 8'hA5, c == 0);
            for (int f = 0; f < frames; f++) begin
                slave_phase(c, 1'b0, sample_of(f, 1'b0, c), 1'b1);
                slave_phase(c, 1'b1, sample_of(f, 1'b1, c), 1'b1);
            end
            repeat (8) @(negedge clk);
            chk("R6", "slave sample count", rx_n, exp_n);
            compare(req_of(c), exp_n);
        end

        // master runs (R7, R8)
        for (int c = 0; c < 3; c++) begin
            int waited;
            fmt = 2'(c); master = 1'b1; ref_en = 1'b0;
            do_reset();
            repeat (40) @(negedge clk);
            chk("R8", "master without ref_en undriven", {clk_oe, sclk_out, lrclk_out}, 0);
            chk("R8", "no samples without ref_en", rx_n, 0);
            tx_fmt = c; tx_on = 1'b1;
            ref_en = 1'b1;
            repeat (2) @(negedge clk);
            chk("R7", "clk_oe in master", clk_oe, 1);
            waited = 0;
            while (rx_n < 32 && waited < 12000) begin
                @(negedge clk);
                waited++;
            end
            chk("R7", "master sample count reached", rx_n >= 32, 1);
            compare(req_of(c), 32);
            tx_on = 1'b0;
            ref_en = 1'b0;
            @(negedge clk);
            chk("R8", "ref_en dropped, clocks released", {clk_oe, sclk_out, lrclk_out}, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule